// File: doc/BRIEF.md
# CAN Error-State Escalation Supervisor

This block sits beside a CAN controller and watches its transmit and receive error counters. From the two counters it derives a live severity level: active, warning, passive or bus-off. It keeps a recorded level. Only error-state events more severe than that recorded level are armed. When an armed event fires, or a poll finds that the level has risen to warning or above, the block detaches the node by dropping the transceiver enable. This happens at the warning level, well before the controller would reach bus-off by itself.

Polls come from an internal interval timer or from an external strobe. A poll copies the live level into the recorded level whenever the two differ, so the armed set also relaxes when the counters heal. A reconnect request brings a detached node back in listen-only mode, where the node sends nothing while the receive counter heals on other nodes' traffic. The node moves to normal mode only once both counters are below the warning threshold. The CAN protocol engine itself lies outside this block.

Top module: `can_err_supervisor`

## Requirements
- R1: After a poll, `state_o` equals the live level, encoded 0 active, 1 warning, 2 passive, 3 bus-off. Bus-off applies when the transmit count exceeds 255. Otherwise passive applies when either count is 128 or more. Otherwise warning applies when either count is 96 or more. Otherwise the level is active.
- R2: While reset is asserted and directly after it, the transceiver enable, listen-only and normal outputs are 0 and `state_o` is 0.
- R3: A reconnect request while detached enables the transceiver in listen-only mode on the next cycle. Normal mode stays low at that point.
- R4: In listen-only mode the node moves to normal mode on the cycle after both counters are seen below 96. It stays in listen-only mode as long as either counter is 96 or more.
- R5: A state interrupt is armed when the live level is above the recorded level. An armed interrupt updates `state_o` on the next cycle. If the live level is warning or above, it drops the transceiver enable, listen-only and normal outputs in the same cycle, and they stay low.
- R6: A state interrupt whose live level is equal to or below the recorded level is ignored. Both `state_o` and the link outputs are left unchanged. In passive state, for example, a warning-level interrupt has no effect.
- R7: A poll (strobe or timer) that sees a live level different from the recorded one updates `state_o` on the next cycle, upward or downward. If the poll sees a rise to warning or above, the node detaches in the same cycle, as in R5.
- R8: With a non-zero poll interval of N cycles, a change in level reaches `state_o` within N+1 cycles without any strobe. An interval of 0 disables the timer.
- R9: A reconnect request while the transceiver is enabled is ignored. A node in normal mode stays in normal mode.
- R10: Listen-only and normal modes are never active together. Either mode implies an enabled transceiver. Normal mode is never entered directly from listen-only without the counter check of R4, and never entered straight from detached.
- R11: A state interrupt and a poll in the same cycle produce a single update and a single detach.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tec_i | input | CNT_W | Transmit error count |
| rec_i | input | CNT_W | Receive error count |
| state_irq_i | input | 1 | Error-state change interrupt from the controller |
| poll_stb_i | input | 1 | External poll strobe |
| reconnect_i | input | 1 | Request to rejoin the bus |
| xcvr_en_o | output | 1 | Transceiver enable |
| listen_only_o | output | 1 | Controller in listen-only (no transmit) mode |
| normal_mode_o | output | 1 | Controller in normal mode |
| state_o | output | 2 | Recorded error level |

## Verification
The state interrupt and a poll can land in the same cycle. In that cycle both paths want to update the recorded level, and both want to detach the node. The bench provokes this by raising the transmit count past bus-off while the node is in listen-only mode, and pulsing the interrupt and the poll strobe together. It checks three things: the transceiver enable drops in that same cycle, the recorded level lands once at bus-off, and the link stays detached afterwards. A second instance with the timer enabled shows that the periodic poll alone picks up a level change within the interval.

// File: rtl/can_es_pkg.sv
package can_es_pkg;
  typedef enum logic [1:0] {
    ES_ACTIVE  = 2'd0,
    ES_WARN    = 2'd1,
    ES_PASSIVE = 2'd2,
    ES_BUSOFF  = 2'd3
  } es_lvl_e;

  typedef enum logic [1:0] {
    LK_OFF    = 2'd0,
    LK_LISTEN = 2'd1,
    LK_NORMAL = 2'd2
  } link_e;
endpackage

// File: rtl/can_es_classify.sv
module can_es_classify
  import can_es_pkg::*;
#(
  parameter int CNT_W    = 9,
  parameter int WARN_LIM = 96,
  parameter int PASS_LIM = 128,
  parameter int BOFF_LIM = 255
) (
  input  logic [CNT_W-1:0] tec_i,
  input  logic [CNT_W-1:0] rec_i,
  output es_lvl_e          lvl_o,
  output logic             quiet_o
);
  localparam logic [CNT_W-1:0] WARN_C = CNT_W'(WARN_LIM);
  localparam logic [CNT_W-1:0] PASS_C = CNT_W'(PASS_LIM);
  localparam logic [CNT_W-1:0] BOFF_C = CNT_W'(BOFF_LIM);

  logic tec_warn, rec_warn, any_pass, tx_off;

  assign tec_warn = tec_i >= WARN_C;
  assign rec_warn = rec_i >= WARN_C;
  assign any_pass = (tec_i >= PASS_C) || (rec_i >= PASS_C);
  assign tx_off   = tec_i > BOFF_C;
  assign quiet_o  = !tec_warn && !rec_warn;

  always_comb begin
    if (tx_off)                    lvl_o = ES_BUSOFF;
    else if (any_pass)             lvl_o = ES_PASSIVE;
    else if (tec_warn || rec_warn) lvl_o = ES_WARN;
    else                           lvl_o = ES_ACTIVE;
  end
endmodule

// File: rtl/can_es_poll_timer.sv
module can_es_poll_timer #(
  parameter int POLL_CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int LIM = (POLL_CYCLES > 0) ? POLL_CYCLES - 1 : 0;
  localparam int PW  = $clog2(LIM + 2);

  generate
    if (POLL_CYCLES > 0) begin : g_timer
      logic [PW-1:0] cnt_q;
      logic          tick_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          cnt_q  <= '0;
          tick_q <= 1'b0;
        end else begin
          tick_q <= (cnt_q == PW'(LIM));
          cnt_q  <= (cnt_q == PW'(LIM)) ? '0 : cnt_q + 1'b1;
        end
      end
      assign tick_o = tick_q;
    end else begin : g_off
      logic tick_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) tick_q <= 1'b0;
        else         tick_q <= 1'b0;
      end
      assign tick_o = tick_q;
    end
  endgenerate
endmodule

// File: rtl/can_es_tracker.sv
module can_es_tracker
  import can_es_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  es_lvl_e lvl_i,
  input  logic    irq_i,
  input  logic    poll_i,
  output es_lvl_e state_o,
  output logic    escal_o
);
  es_lvl_e state_q;
  logic    armed, fire, poll_chg, upd;

  // events above the recorded level are the only armed ones
  assign armed    = lvl_i > state_q;
  assign fire     = irq_i && armed;
  assign poll_chg = poll_i && (lvl_i != state_q);
  assign upd      = fire || poll_chg;
  assign escal_o  = upd && armed && (lvl_i != ES_ACTIVE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  state_q <= ES_ACTIVE;
    else if (upd) state_q <= lvl_i;
  end

  assign state_o = state_q;
endmodule

// File: rtl/can_es_link_fsm.sv
module can_es_link_fsm
  import can_es_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic escal_i,
  input  logic reconnect_i,
  input  logic quiet_i,
  output logic xcvr_en_o,
  output logic listen_only_o,
  output logic normal_mode_o
);
  link_e link_q, link_d;
  logic  detach;

  assign detach = escal_i && (link_q != LK_OFF);

  always_comb begin
    link_d = link_q;
    unique case (link_q)
      LK_OFF:    if (reconnect_i) link_d = LK_LISTEN;
      LK_LISTEN: if (detach)       link_d = LK_OFF;
                 else if (quiet_i) link_d = LK_NORMAL;
      LK_NORMAL: if (detach)       link_d = LK_OFF;
      default:   link_d = LK_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) link_q <= LK_OFF;
    else         link_q <= link_d;
  end

  // detach cuts the outputs in the cycle of the event, not one later
  assign xcvr_en_o     = (link_q != LK_OFF) && !detach;
  assign listen_only_o = (link_q == LK_LISTEN) && !detach;
  assign normal_mode_o = (link_q == LK_NORMAL) && !detach;
endmodule

// File: rtl/can_err_supervisor.sv
module can_err_supervisor
  import can_es_pkg::*;
#(
  parameter int CNT_W       = 9,
  parameter int WARN_LIM    = 96,
  parameter int PASS_LIM    = 128,
  parameter int BOFF_LIM    = 255,
  parameter int POLL_CYCLES = 1000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] tec_i,
  input  logic [CNT_W-1:0] rec_i,
  input  logic             state_irq_i,
  input  logic             poll_stb_i,
  input  logic             reconnect_i,
  output logic             xcvr_en_o,
  output logic             listen_only_o,
  output logic             normal_mode_o,
  output logic [1:0]       state_o
);
  es_lvl_e lvl, state;
  logic    quiet, tick, poll_any, escal;

  can_es_classify #(
    .CNT_W(CNT_W), .WARN_LIM(WARN_LIM), .PASS_LIM(PASS_LIM), .BOFF_LIM(BOFF_LIM)
  ) u_classify (
    .tec_i(tec_i), .rec_i(rec_i), .lvl_o(lvl), .quiet_o(quiet)
  );

  can_es_poll_timer #(.POLL_CYCLES(POLL_CYCLES)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick)
  );

  assign poll_any = tick || poll_stb_i;

  can_es_tracker u_tracker (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(lvl), .irq_i(state_irq_i),
    .poll_i(poll_any), .state_o(state), .escal_o(escal)
  );

  can_es_link_fsm u_link (
    .clk_i(clk_i), .rst_ni(rst_ni), .escal_i(escal), .reconnect_i(reconnect_i),
    .quiet_i(quiet), .xcvr_en_o(xcvr_en_o), .listen_only_o(listen_only_o),
    .normal_mode_o(normal_mode_o)
  );

  assign state_o = state;
endmodule

// File: rtl/can_err_supervisor_chk.sv
module can_err_supervisor_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       state_irq_i,
  input logic       poll_any_i,
  input logic       reconnect_i,
  input logic       xcvr_en_o,
  input logic       listen_only_o,
  input logic       normal_mode_o,
  input logic [1:0] state_o
);
  a_r10_modes_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(listen_only_o && normal_mode_o));

  a_r10_mode_needs_xcvr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (listen_only_o || normal_mode_o) |-> xcvr_en_o);

  a_r3_listen_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!xcvr_en_o && reconnect_i) |=> !normal_mode_o);

  a_r9_no_fall_back_to_listen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    normal_mode_o |=> !listen_only_o);

  a_r5_escalation_detaches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_o > $past(state_o)) && !$past(reconnect_i)) |-> !xcvr_en_o);

  a_r7_update_needs_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o != $past(state_o)) |-> $past(state_irq_i || poll_any_i));
endmodule

bind can_err_supervisor can_err_supervisor_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .state_irq_i(state_irq_i), .poll_any_i(poll_any),
  .reconnect_i(reconnect_i), .xcvr_en_o(xcvr_en_o), .listen_only_o(listen_only_o),
  .normal_mode_o(normal_mode_o), .state_o(state_o)
);

// File: tb/can_err_supervisor_bench.sv
`timescale 1ns/1ps
module can_err_supervisor_bench;
  localparam int CW = 9;
  localparam int TP = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [CW-1:0] tec = '0, rec = '0, rec_b = '0;
  logic irq = 0, poll = 0, recon = 0;
  logic xcvr, lsn, nrm, xcvr_b, lsn_b, nrm_b;
  logic [1:0] st, st_b;

  int checks = 0;
  int fails  = 0;

  can_err_supervisor #(.CNT_W(CW), .POLL_CYCLES(0)) u_can_err_supervisor (
    .clk_i(clk), .rst_ni(rst_n), .tec_i(tec), .rec_i(rec), .state_irq_i(irq),
    .poll_stb_i(poll), .reconnect_i(recon), .xcvr_en_o(xcvr), .listen_only_o(lsn),
    .normal_mode_o(nrm), .state_o(st)
  );

  can_err_supervisor #(.CNT_W(CW), .POLL_CYCLES(TP)) u_can_err_supervisor_tmr (
    .clk_i(clk), .rst_ni(rst_n), .tec_i('0), .rec_i(rec_b), .state_irq_i(1'b0),
    .poll_stb_i(1'b0), .reconnect_i(1'b0), .xcvr_en_o(xcvr_b), .listen_only_o(lsn_b),
    .normal_mode_o(nrm_b), .state_o(st_b)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic link(input string tag, input int x, input int l, input int n);
    check({tag, " xcvr"}, int'(xcvr), x);
    check({tag, " listen"}, int'(lsn), l);
    check({tag, " normal"}, int'(nrm), n);
  endtask

  function automatic int exp_lvl(input int t, input int r);
    if (t > 255) return 3;
    if (t >= 128 || r >= 128) return 2;
    if (t >= 96 || r >= 96) return 1;
    return 0;
  endfunction

  task automatic nxt();
    @(negedge clk);
    #1;
  endtask

  // pulse poll and/or irq for one cycle with the given counters
  task automatic pulse(input int t, input int r, input bit p, input bit i);
    @(negedge clk);
    tec = CW'(t); rec = CW'(r); poll = p; irq = i;
    #1;
  endtask

  task automatic release_pulses();
    @(negedge clk);
    poll = 0; irq = 0; recon = 0;
    #1;
  endtask

  task automatic reconnect();
    @(negedge clk);
    recon = 1;
    #1;
    release_pulses();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    int tv[8];
    int rv[6];
    tv = '{0, 95, 96, 127, 128, 255, 256, 300};
    rv = '{0, 95, 96, 127, 128, 200};

    #1;
    link("R2 in reset", 0, 0, 0);
    check("R2 state in reset", int'(st), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    nxt();
    link("R2 after reset", 0, 0, 0);
    check("R2 state after reset", int'(st), 0);

    // R8: timer-only poll on the second instance
    @(negedge clk);
    rec_b = CW'(130);
    repeat (TP + 1) nxt();
    check("R8 timer poll state", int'(st_b), 2);
    check("R8 timer instance stays detached", int'(xcvr_b), 0);

    // R1: classification sweep, node detached
    foreach (tv[a]) begin
      foreach (rv[b]) begin
        pulse(tv[a], rv[b], 1'b1, 1'b0);
        release_pulses();
        check($sformatf("R1 level tec=%0d rec=%0d", tv[a], rv[b]), int'(st),
              exp_lvl(tv[a], rv[b]));
        check("R1 no link while detached", int'(xcvr), 0);
      end
    end
    pulse(0, 0, 1'b1, 1'b0);
    release_pulses();
    check("R7 poll back to active", int'(st), 0);

    // R3/R4: reconnect with rec above warning
    pulse(0, 100, 1'b1, 1'b0);
    release_pulses();
    check("R1 warn recorded", int'(st), 1);
    reconnect();
    link("R3 reconnect enters listen", 1, 1, 0);
    repeat (3) nxt();
    link("R4 held in listen while rec>=96", 1, 1, 0);
    @(negedge clk);
    rec = CW'(50);
    nxt();
    link("R4 normal after healing", 1, 0, 1);
    pulse(0, 50, 1'b1, 1'b0);
    release_pulses();
    check("R7 downward poll", int'(st), 0);
    link("R7 downward poll keeps link", 1, 0, 1);

    // R9: reconnect ignored while enabled
    reconnect();
    link("R9 reconnect ignored", 1, 0, 1);

    // R6: interrupt at the recorded level
    pulse(0, 50, 1'b0, 1'b1);
    release_pulses();
    check("R6 same-level irq state", int'(st), 0);
    link("R6 same-level irq link", 1, 0, 1);

    // R5: armed interrupt at warning detaches in the same cycle
    pulse(100, 50, 1'b0, 1'b1);
    link("R5 same-cycle detach", 0, 0, 0);
    release_pulses();
    check("R5 state after irq", int'(st), 1);
    link("R5 detached next cycle", 0, 0, 0);
    repeat (3) nxt();
    link("R5 stays detached", 0, 0, 0);

    // R6: non-armed interrupts ignored
    pulse(100, 50, 1'b0, 1'b1);
    release_pulses();
    check("R6 equal-level irq ignored", int'(st), 1);
    pulse(50, 50, 1'b0, 1'b1);
    release_pulses();
    check("R6 lower-level irq ignored", int'(st), 1);
    check("R6 lower-level irq link", int'(xcvr), 0);
    pulse(50, 50, 1'b1, 1'b0);
    release_pulses();
    check("R7 poll heals state", int'(st), 0);

    // R7: poll escalation detaches from normal
    reconnect();
    link("R3 second reconnect", 1, 1, 0);
    nxt();
    link("R4 quiet counters reach normal", 1, 0, 1);
    pulse(50, 130, 1'b1, 1'b0);
    link("R7 poll escalation same-cycle detach", 0, 0, 0);
    release_pulses();
    check("R7 passive recorded", int'(st), 2);
    link("R7 detached after poll", 0, 0, 0);

    // R6 in passive: warning interrupt masked
    reconnect();
    link("R3 reconnect from passive", 1, 1, 0);
    pulse(50, 100, 1'b0, 1'b1);
    link("R6 warning irq masked in passive", 1, 1, 0);
    release_pulses();
    check("R6 passive kept", int'(st), 2);
    link("R6 still listening", 1, 1, 0);

    // R11: irq and poll in the same cycle
    pulse(300, 100, 1'b1, 1'b1);
    link("R11 same-cycle detach", 0, 0, 0);
    release_pulses();
    check("R11 single update to bus-off", int'(st), 3);
    link("R11 detached", 0, 0, 0);
    nxt();
    check("R11 state held", int'(st), 3);
    link("R11 stays detached", 0, 0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule